// File: doc/BRIEF.md
# Cascadable FIFO Slice with Token-Passing Depth Expansion

This block is one slice of a FIFO that can be deepened by connecting identical slices in a ring. Each slice has its own storage of `DEPTH` words, a write pointer and a read pointer. A slice also keeps a write token and a read token. Every slice sees the same write strobe, read strobe and write data. Only the slice that holds the write token stores a word, and only the slice that holds the read token returns one. When a slice writes or reads its last location, it hands that token to the next slice in the ring over a two-wire expansion link. Bit 0 of the link carries the write token and bit 1 carries the read token. The receiving slice takes the token on the same clock edge and uses its own location zero for the next access.

A first-load strap, active low, marks the slice that holds both tokens after reset. All other slices start with neither token. The outputs of the ring are combined outside the slices. The active-low full flags are ORed together, and so are the active-low empty flags, so a composite flag asserts only when every slice asserts it. The read buses are also ORed, because a slice drives its read bus only in the cycle it returns a word. A static standalone strap makes the slice a complete FIFO of its own. In that mode it holds both tokens permanently, its pointers wrap inside the slice, it ignores the link input, and link bit 0 becomes a more-than-half-full indication.

Top module: `chain_fifo_slice`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, the slice shows the following state. `empty_n` is low, `full_n` is high, `rd_valid` is low, `rd_data` is zero and `xout` is zero. Both pointers are at location zero. A slice with `first_load_n` low holds both tokens, and any other slice holds neither.
- R2: Words come out in the order they were written. A read strobe accepted at clock edge N gives `rd_valid` high with the word on `rd_data` in the cycle after edge N.
- R3: After `DEPTH` accepted writes with no reads, `full_n` goes low. While it is low, write strobes are ignored and the stored contents do not change.
- R4: While the slice is empty, a read strobe is ignored: `rd_valid` stays low and `empty_n` stays low.
- R5: In standalone mode, `xout[0]` is high exactly when the slice holds more than `DEPTH/2` words, and `xout[1]` is always low.
- R6: In ring mode, an accepted write to location `DEPTH-1` raises `xout[0]` for one cycle, in the same cycle as the write strobe. The slice whose `xin[0]` sees the pulse takes the write token, and its next write goes to its location zero.
- R7: In ring mode, an accepted read of location `DEPTH-1` raises `xout[1]` for one cycle, in the same cycle as the read strobe. The slice whose `xin[1]` sees the pulse takes the read token.
- R8: A slice without the write token ignores the write strobe, and a slice without the read token ignores the read strobe. `rd_data` is zero in every cycle where `rd_valid` is low.
- R9: Across a ring, ORing the `full_n` outputs gives a flag that is low exactly when the whole ring holds `DEPTH` times the slice count. ORing the `empty_n` outputs gives a flag that is low exactly when the ring holds nothing.
- R10: A write and a read strobed in the same cycle are both carried out when the FIFO is neither full nor empty. When it is empty, only the write is carried out. When it is full, only the read is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| standalone | input | 1 | Static strap: 1 selects a self-contained FIFO, 0 selects ring mode |
| first_load_n | input | 1 | Static strap, active low: the slice that owns both tokens after reset |
| xin | input | 2 | Link from the previous slice: bit 0 passes the write token, bit 1 passes the read token |
| xout | output | 2 | Link to the next slice. In standalone mode, bit 0 is the more-than-half indication |
| wr_req | input | 1 | Write strobe, one word per cycle, shared by the whole ring |
| wr_data | input | DW | Write word |
| full_n | output | 1 | Active-low full flag of this slice |
| rd_req | input | 1 | Read strobe, one word per cycle, shared by the whole ring |
| rd_valid | output | 1 | High in the cycle a returned word is on `rd_data` |
| rd_data | output | DW | Returned word, zero when `rd_valid` is low |
| empty_n | output | 1 | Active-low empty flag of this slice |

## Verification
The bench uses `DEPTH` = 4 and `DW` = 8. With only four words per slice, a token goes around a ring of three slices in twelve writes, so every wrap of the write token and the read token, including the return to the first-load slice, happens many times in a short run. The same parameters put the standalone full boundary and the half boundary only a few words apart. A single standalone slice and the three-slice ring receive the same strobes side by side. This shows the full and empty limits at 4 words against 12 words under one stimulus.

// File: rtl/chain_fifo_pkg.sv
package chain_fifo_pkg;
  // Bit positions on the two-wire expansion link
  localparam int LINK_WR = 0;
  localparam int LINK_RD = 1;
  localparam int LINK_W  = 2;

  typedef logic [LINK_W-1:0] link_t;
endpackage

// File: rtl/chain_fifo_tok_ptr.sv
// One side (write or read) of a slice: token ownership plus a wrapping pointer.
module chain_fifo_tok_ptr #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          standalone,
  input  logic          own_at_reset,
  input  logic          strobe,
  input  logic          room,
  input  logic          take,
  output logic [AW-1:0] ptr,
  output logic          fire,
  output logic          give
);
  logic holds;
  logic at_last;

  assign at_last = (ptr == AW'(DEPTH - 1));
  assign fire    = strobe & holds & room;
  assign give    = fire & at_last & ~standalone;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      holds <= standalone | own_at_reset;
    end else begin
      if (fire) begin
        ptr <= at_last ? '0 : ptr + AW'(1);
      end
      // a returning token wins over the one leaving (ring of one slice)
      holds <= standalone | (holds & ~give) | take;
    end
  end
endmodule

// File: rtl/chain_fifo_level.sv
// Occupancy counter of one slice and its registered flags.
module chain_fifo_level #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_fire,
  input  logic rd_fire,
  output logic at_full,
  output logic at_empty,
  output logic full_n,
  output logic empty_n,
  output logic half_over
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;

  always_comb begin
    unique case ({wr_fire, rd_fire})
      2'b10:   cnt_nx = cnt + CW'(1);
      2'b01:   cnt_nx = cnt - CW'(1);
      default: cnt_nx = cnt;
    endcase
  end

  assign at_full  = (cnt == CW'(DEPTH));
  assign at_empty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      full_n    <= 1'b1;
      empty_n   <= 1'b0;
      half_over <= 1'b0;
    end else begin
      cnt       <= cnt_nx;
      full_n    <= (cnt_nx != CW'(DEPTH));
      empty_n   <= (cnt_nx != '0);
      half_over <= (cnt_nx > CW'(DEPTH / 2));
    end
  end
endmodule

// File: rtl/chain_fifo_store.sv
// Simple dual-port storage with a registered read port (block RAM friendly).
module chain_fifo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 9,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[wa] <= wd;
    end
    if (re) begin
      rq <= mem[ra];
    end
  end
endmodule

// File: rtl/chain_fifo_slice.sv
module chain_fifo_slice
  import chain_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          standalone,
  input  logic          first_load_n,
  input  logic [1:0]    xin,
  output logic [1:0]    xout,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  output logic          full_n,
  input  logic          rd_req,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          empty_n
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          at_full;
  logic          at_empty;
  logic          half_over;
  link_t         strobe_v;
  link_t         room_v;
  link_t         fire_v;
  link_t         give_v;
  logic [AW-1:0] ptr_v [LINK_W];
  logic [DW-1:0] rq;

  assign strobe_v[LINK_WR] = wr_req;
  assign strobe_v[LINK_RD] = rd_req;
  assign room_v[LINK_WR]   = ~at_full;
  assign room_v[LINK_RD]   = ~at_empty;

  // one token/pointer unit per side; both start owned by the first-load slice
  for (genvar g = 0; g < LINK_W; g++) begin : g_side
    chain_fifo_tok_ptr #(.DEPTH(DEPTH), .AW(AW)) tok_i (
      .clk          (clk),
      .rst          (rst),
      .standalone   (standalone),
      .own_at_reset (~first_load_n),
      .strobe       (strobe_v[g]),
      .room         (room_v[g]),
      .take         (xin[g]),
      .ptr          (ptr_v[g]),
      .fire         (fire_v[g]),
      .give         (give_v[g])
    );
  end

  chain_fifo_level #(.DEPTH(DEPTH), .CW(CW)) level_i (
    .clk       (clk),
    .rst       (rst),
    .wr_fire   (fire_v[LINK_WR]),
    .rd_fire   (fire_v[LINK_RD]),
    .at_full   (at_full),
    .at_empty  (at_empty),
    .full_n    (full_n),
    .empty_n   (empty_n),
    .half_over (half_over)
  );

  chain_fifo_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) store_i (
    .clk (clk),
    .we  (fire_v[LINK_WR]),
    .wa  (ptr_v[LINK_WR]),
    .wd  (wr_data),
    .re  (fire_v[LINK_RD]),
    .ra  (ptr_v[LINK_RD]),
    .rq  (rq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= fire_v[LINK_RD];
    end
  end

  // bus stays zero unless this slice returned a word, so a ring can OR buses
  assign rd_data = rd_valid ? rq : '0;

  // link pulses are same-cycle so the token never sits in flight
  always_comb begin
    if (standalone) begin
      xout          = '0;
      xout[LINK_WR] = half_over;
    end else begin
      xout = give_v;
    end
  end
endmodule

// File: rtl/chain_fifo_slice_chk.sv
module chain_fifo_slice_chk (
  input logic       clk,
  input logic       rst,
  input logic       standalone,
  input logic [1:0] xout,
  input logic       wr_req,
  input logic       rd_req,
  input logic       full_n,
  input logic       empty_n,
  input logic       rd_valid
);
  // R3 R4: a slice is never full and empty at once
  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(!full_n && !empty_n));

  assert_empty_read_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    !empty_n |=> !rd_valid);

  assert_full_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (!full_n && !rd_req) |=> !full_n);

  assert_solo_link_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    standalone |-> !xout[1]);

  assert_wr_pass_on_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (!standalone && xout[0]) |-> wr_req);

  assert_rd_pass_on_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    (!standalone && xout[1]) |-> rd_req);
endmodule

bind chain_fifo_slice chain_fifo_slice_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .standalone (standalone),
  .xout       (xout),
  .wr_req     (wr_req),
  .rd_req     (rd_req),
  .full_n     (full_n),
  .empty_n    (empty_n),
  .rd_valid   (rd_valid)
);

// File: tb/chain_fifo_slice_tb_top.sv
module chain_fifo_slice_tb_top;
  localparam int DEPTH = 4;
  localparam int DW    = 8;
  localparam int N     = 3;
  localparam int CAP   = DEPTH * N;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst     = 1'b1;
  logic          wr_req  = 1'b0;
  logic          rd_req  = 1'b0;
  logic [DW-1:0] wr_data = '0;

  logic [1:0]    s_xout;
  logic          s_full_n, s_empty_n, s_rv;
  logic [DW-1:0] s_rd;

  chain_fifo_slice #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .standalone(1'b1), .first_load_n(1'b1), .xin(2'b00),
    .xout(s_xout), .wr_req(wr_req), .wr_data(wr_data), .full_n(s_full_n),
    .rd_req(rd_req), .rd_valid(s_rv), .rd_data(s_rd), .empty_n(s_empty_n)
  );

  logic [N-1:0][1:0]    c_xout;
  logic [N-1:0]         c_full_n, c_empty_n, c_rv;
  logic [N-1:0][DW-1:0] c_rd;

  for (genvar k = 0; k < N; k++) begin : g_link
    chain_fifo_slice #(.DEPTH(DEPTH), .DW(DW)) link_i (
      .clk(clk), .rst(rst), .standalone(1'b0),
      .first_load_n((k == 0) ? 1'b0 : 1'b1),
      .xin(c_xout[(k + N - 1) % N]), .xout(c_xout[k]),
      .wr_req(wr_req), .wr_data(wr_data), .full_n(c_full_n[k]),
      .rd_req(rd_req), .rd_valid(c_rv[k]), .rd_data(c_rd[k]), .empty_n(c_empty_n[k])
    );
  end

  // composite ring outputs (R9)
  logic          comp_full_n, comp_empty_n;
  logic [DW-1:0] comp_rd;
  always_comb begin
    comp_full_n  = |c_full_n;
    comp_empty_n = |c_empty_n;
    comp_rd      = '0;
    for (int k = 0; k < N; k++) comp_rd = comp_rd | c_rd[k];
  end

  // reference model state
  logic [DW-1:0] sq[$];
  logic [DW-1:0] cq[$];
  int wpos = 0;
  int rpos = 0;
  logic          e_s_full_n = 1'b1, e_s_empty_n = 1'b0, e_s_hf = 1'b0, e_s_rv = 1'b0;
  logic [DW-1:0] e_s_rd = '0;
  logic          e_c_full_n = 1'b1, e_c_empty_n = 1'b0;
  logic [N-1:0]  e_c_rv = '0;
  logic [DW-1:0] e_c_rd = '0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_regs();
    chk("R2 solo rd_valid", 32'(s_rv), 32'(e_s_rv));
    chk("R2 solo rd_data",  32'(s_rd), 32'(e_s_rd));
    chk("R3 solo full_n",   32'(s_full_n), 32'(e_s_full_n));
    chk("R4 solo empty_n",  32'(s_empty_n), 32'(e_s_empty_n));
    chk("R5 solo half",     32'(s_xout[0]), 32'(e_s_hf));
    chk("R5 solo xout1",    32'(s_xout[1]), 32'(0));
    chk("R9 ring full_n",   32'(comp_full_n), 32'(e_c_full_n));
    chk("R9 ring empty_n",  32'(comp_empty_n), 32'(e_c_empty_n));
    chk("R2 ring rd_data",  32'(comp_rd), 32'(e_c_rd));
    for (int k = 0; k < N; k++) begin
      chk("R8 slice rd_valid", 32'(c_rv[k]), 32'(e_c_rv[k]));
      chk("R8 slice rd_data", 32'(c_rd[k]), e_c_rv[k] ? 32'(e_c_rd) : 32'(0));
    end
  endtask

  // one clock of stimulus: check the registered results of the last cycle,
  // apply new strobes, check same-cycle link pulses, advance the model
  task automatic step(input logic w, input logic r, input logic [DW-1:0] d);
    logic s_rf, s_wf, c_rf, c_wf;
    @(negedge clk);
    check_regs();
    wr_req  = w;
    rd_req  = r;
    wr_data = d;
    s_rf = r && (sq.size() > 0);
    s_wf = w && (sq.size() < DEPTH);
    c_rf = r && (cq.size() > 0);
    c_wf = w && (cq.size() < CAP);
    #5;
    for (int k = 0; k < N; k++) begin
      chk("R6 write link pulse", 32'(c_xout[k][0]), 32'(c_wf && (wpos == k * DEPTH + DEPTH - 1)));
      chk("R7 read link pulse",  32'(c_xout[k][1]), 32'(c_rf && (rpos == k * DEPTH + DEPTH - 1)));
    end
    // standalone model (R10 ordering: pop before push)
    e_s_rv = s_rf;
    e_s_rd = s_rf ? sq.pop_front() : '0;
    if (s_wf) sq.push_back(d);
    e_s_full_n  = (sq.size() != DEPTH);
    e_s_empty_n = (sq.size() != 0);
    e_s_hf      = (sq.size() > DEPTH / 2);
    // ring model: the read token sits in slice rpos/DEPTH
    for (int k = 0; k < N; k++) e_c_rv[k] = c_rf && ((rpos / DEPTH) == k);
    e_c_rd = c_rf ? cq.pop_front() : '0;
    if (c_rf) rpos = (rpos + 1) % CAP;
    if (c_wf) begin
      cq.push_back(d);
      wpos = (wpos + 1) % CAP;
    end
    e_c_full_n  = (cq.size() != CAP);
    e_c_empty_n = (cq.size() != 0);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R1: reset state, before and after release
    chk("R1 solo empty_n", 32'(s_empty_n), 32'(0));
    chk("R1 solo full_n",  32'(s_full_n), 32'(1));
    chk("R1 solo rd_valid", 32'(s_rv), 32'(0));
    chk("R1 solo xout",    32'(s_xout), 32'(0));
    chk("R1 ring xout",    32'(c_xout), 32'(0));
    chk("R1 ring empty_n", 32'(c_empty_n), 32'(0));
    chk("R1 ring full_n",  32'(c_full_n), 32'(7));
    chk("R1 ring rd_data", 32'(comp_rd), 32'(0));
    rst = 1'b0;
    // R4: read on empty ignored
    step(1'b0, 1'b1, 8'h00);
    // R1 R6: first writes land in the first-load slice, then move on; R3 solo full
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 8'(8'h10 + i));
    // R10: simultaneous read and write
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 8'(8'h30 + i));
    // fill ring to capacity and beyond (R3 R9)
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 8'(8'h50 + i));
    // R10 on full: read carried out, write dropped for solo
    step(1'b1, 1'b1, 8'h77);
    // drain everything and read past empty (R4 R7 R9)
    for (int i = 0; i < 15; i++) step(1'b0, 1'b1, 8'h00);
    // R10 on empty: only the write happens
    step(1'b1, 1'b1, 8'h99);
    step(1'b0, 1'b1, 8'h00);
    // mixed traffic, write-heavy then read-heavy
    for (int i = 0; i < 600; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      if (i < 300) step(seed[17:16] != 2'b00, seed[19:18] == 2'b00, seed[27:20]);
      else         step(seed[17:16] == 2'b00, seed[19:18] != 2'b00, seed[27:20]);
    end
    step(1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 8'h00);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule